// File: doc/BRIEF.md
# Shift Unit with Latched Funnel Count

This block is the shift execution unit of a 32-bit integer datapath. It performs logical left, logical right and arithmetic right shifts of one source operand. It also performs a double-width funnel shift. For the funnel shift, the two sources are joined into one 64-bit value and a 32-bit window is taken from it. The funnel shift has no count operand of its own. It uses a 5-bit count that the unit keeps in a small status field, and that field is loaded by every logical right shift.

Issue an operation by raising `in_valid` with the opcode, both sources and the shift amount. The result appears registered one cycle later with `out_valid`. Software that wants a funnel shift by N first issues a logical right shift by N, for example on a scratch value, and then issues the funnel shift. The unit also holds a single condition-code bit. Only its own write port can change that bit, and no shift operation touches it.

Top module: `shf_unit`

## Requirements
- R1: With `in_op` = 0 (shift left), the result one cycle after issue is `in_a` shifted left by `in_amt`, with zeros filling from the bottom, and `out_valid` is 1 in that cycle.
- R2: With `in_op` = 1 (logical right shift), the result one cycle after issue is `in_a` shifted right by `in_amt`, with zeros filling from the top.
- R3: With `in_op` = 2 (arithmetic right shift), the result one cycle after issue is `in_a` shifted right by `in_amt`, with copies of bit 31 filling from the top.
- R4: With `in_op` = 3 (funnel shift), the result is bits [c+31:c] of the 64-bit value {`in_a`,`in_b`}, where `in_b` is the low half and c is the saved count as it stood before this operation. When c is 0 the result equals `in_b`.
- R5: For the three single-operand shifts, a shift amount of 0 returns `in_a` unchanged.
- R6: A logical right shift loads its 5-bit amount into `saved_cnt`, and the new value is visible on the clock edge that also delivers that shift's result. Shift left, arithmetic right shift, funnel shift and idle cycles leave `saved_cnt` unchanged.
- R7: After synchronous reset, `out_valid`, `out_result`, `saved_cnt` and `cc` are all 0.
- R8: `cc` takes the value of `cc_wdata` on the edge after `cc_wr` is 1. No shift operation of any kind changes `cc`.
- R9: When no operation is issued, `out_valid` is 0 in the next cycle and `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issues an operation this cycle |
| in_op | input | 2 | 0 shift left, 1 logical right, 2 arithmetic right, 3 funnel |
| in_a | input | 32 | First source; high half of the funnel pair |
| in_b | input | 32 | Second source; low half of the funnel pair |
| in_amt | input | 5 | Shift amount for the single-operand shifts |
| cc_wr | input | 1 | Writes the condition-code bit |
| cc_wdata | input | 1 | Value written to the condition-code bit |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 32 | Registered shift result |
| saved_cnt | output | 5 | Funnel count latched by the last logical right shift |
| cc | output | 1 | Condition-code bit |

## Verification
A saved count that is wrong, or that is loaded by the wrong operation, stays hidden until the next funnel shift. At that point it shows up on `out_result` as a window shifted off by the error. It is also visible on `saved_cnt` one cycle after the operation that loaded it. The bench therefore places an arithmetic right shift and a shift left between a logical right shift and a funnel shift, and it checks `saved_cnt` after every operation. A misrouted bit in the reversal path for left shifts appears as a mirrored result in the cycle after issue. A condition-code bit that is disturbed by a shift shows up on `cc` one cycle later.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int PAIR_W = 2 * DATA_W;

    typedef enum logic [1:0] {
        OP_SLL = 2'd0,
        OP_SRL = 2'd1,
        OP_SRA = 2'd2,
        OP_FSR = 2'd3
    } shf_op_e;

    // Operand set handed to the shared right barrel.
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [CNT_W-1:0]  cnt;
        logic              flip;
    } shf_prep_t;

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/shf_prep.sv
module shf_prep
    import shf_pkg::*;
(
    input  shf_op_e           op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [CNT_W-1:0]  amt,
    input  logic [CNT_W-1:0]  saved,
    output shf_prep_t         prep
);
    always_comb begin
        prep.hi   = '0;
        prep.lo   = src_a;
        prep.cnt  = amt;
        prep.flip = 1'b0;
        unique case (op)
            OP_SLL: begin
                prep.lo   = bit_rev(src_a);
                prep.flip = 1'b1;
            end
            OP_SRL: ;
            OP_SRA: prep.hi = {DATA_W{src_a[DATA_W-1]}};
            OP_FSR: begin
                prep.hi  = src_a;
                prep.lo  = src_b;
                prep.cnt = saved;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shf_rbarrel.sv
module shf_rbarrel #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 5
) (
    input  logic [WIDTH-1:0]  din,
    input  logic [STAGES-1:0] amt,
    output logic [WIDTH-1:0]  dout
);
    logic [WIDTH-1:0] stage [STAGES+1];

    assign stage[0] = din;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stage[k+1] = amt[k] ? (stage[k] >> DIST) : stage[k];
    end

    assign dout = stage[STAGES];
endmodule

// File: rtl/shf_flag_reg.sv
module shf_flag_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [CNT_W-1:0]  in_amt,
    input  logic              cc_wr,
    input  logic              cc_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [CNT_W-1:0]  saved_cnt,
    output logic              cc
);
    shf_op_e           op;
    shf_prep_t         prep;
    logic [PAIR_W-1:0] pair_out;
    logic [DATA_W-1:0] res_d;
    logic              cnt_load;

    assign op = shf_op_e'(in_op);

    shf_prep u_prep (
        .op    (op),
        .src_a (in_a),
        .src_b (in_b),
        .amt   (in_amt),
        .saved (saved_cnt),
        .prep  (prep)
    );

    shf_rbarrel #(.WIDTH(PAIR_W), .STAGES(CNT_W)) u_barrel (
        .din  ({prep.hi, prep.lo}),
        .amt  (prep.cnt),
        .dout (pair_out)
    );

    assign res_d = prep.flip ? bit_rev(pair_out[DATA_W-1:0]) : pair_out[DATA_W-1:0];

    assign cnt_load = in_valid && (op == OP_SRL);

    shf_flag_reg #(.WIDTH(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_load),
        .din  (in_amt),
        .q    (saved_cnt)
    );

    shf_flag_reg #(.WIDTH(1)) u_cc (
        .clk  (clk),
        .rst  (rst),
        .load (cc_wr),
        .din  (cc_wdata),
        .q    (cc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= res_d;
            end
        end
    end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk
    import shf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [CNT_W-1:0]  in_amt,
    input logic              cc_wr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [CNT_W-1:0]  saved_cnt,
    input logic              cc
);
    // R6
    srl_loads_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1) |=> (saved_cnt == $past(in_amt)));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_op == 2'd1) |=> $stable(saved_cnt));

    // R8
    cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cc_wr |=> $stable(cc));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R5
    zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'd3 && in_amt == '0) |=> (out_result == $past(in_a)));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_result == '0 && saved_cnt == '0 && !cc));
endmodule

bind shf_unit shf_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_amt     (in_amt),
    .cc_wr      (cc_wr),
    .out_valid  (out_valid),
    .out_result (out_result),
    .saved_cnt  (saved_cnt),
    .cc         (cc)
);

// File: tb/shf_unit_tb.sv
module shf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [31:0] in_a;
    logic [31:0] in_b;
    logic [4:0]  in_amt;
    logic        cc_wr;
    logic        cc_wdata;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  saved_cnt;
    logic        cc;

    int checks = 0;
    int errors = 0;
    logic [4:0] m_cnt;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shf_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_amt(in_amt), .cc_wr(cc_wr),
        .cc_wdata(cc_wdata), .out_valid(out_valid), .out_result(out_result),
        .saved_cnt(saved_cnt), .cc(cc)
    );

    // op[70:69] a[68:37] b[36:5] amt[4:0]
    localparam int NV = 14;
    localparam logic [70:0] VEC [NV] = '{
        {2'd0, 32'h0000_0001, 32'h0, 5'd31},
        {2'd0, 32'hDEAD_BEEF, 32'h0, 5'd4},
        {2'd0, 32'h1234_5678, 32'h0, 5'd0},
        {2'd1, 32'h8000_0000, 32'h0, 5'd31},
        {2'd3, 32'hAAAA_5555, 32'h0F0F_F0F0, 5'd2},
        {2'd1, 32'hF000_000F, 32'h0, 5'd8},
        {2'd2, 32'h8000_0010, 32'h0, 5'd4},
        {2'd0, 32'h0000_FFFF, 32'h0, 5'd16},
        {2'd3, 32'h1122_3344, 32'h5566_7788, 5'd1},
        {2'd2, 32'h7FFF_FFFF, 32'h0, 5'd31},
        {2'd2, 32'hC000_0000, 32'h0, 5'd0},
        {2'd1, 32'hCAFE_F00D, 32'h0, 5'd0},
        {2'd3, 32'h0123_4567, 32'h89AB_CDEF, 5'd17},
        {2'd1, 32'hFFFF_FFFF, 32'h0, 5'd13}
    };

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] amt,
                                          input logic [4:0] sc);
        logic [63:0] pr;
        case (op)
            2'd0: return a << amt;
            2'd1: return a >> amt;
            2'd2: return 32'($signed(a) >>> amt);
            default: begin
                pr = {a, b} >> sc;
                return pr[31:0];
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [4:0] amt);
        if (amt == 5'd0 && op != 2'd3) return "R5";
        case (op)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] amt);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_amt = amt;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
        in_amt = '0; cc_wr = 1'b0; cc_wdata = 1'b0;
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7", {31'b0, out_valid}, 32'd0);
        check("R7", out_result, 32'd0);
        check("R7", {27'b0, saved_cnt}, 32'd0);
        check("R7", {31'b0, cc}, 32'd0);
        rst = 1'b0;
        m_cnt = 5'd0;

        // R4 funnel with count 0 right after reset returns in_b
        issue(2'd3, 32'hFEED_0001, 32'h0BAD_CAFE, 5'd9);
        check("R4", out_result, 32'h0BAD_CAFE);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [31:0] a, b, exp;
            logic [4:0]  amt;
            op = VEC[i][70:69]; a = VEC[i][68:37]; b = VEC[i][36:5]; amt = VEC[i][4:0];
            exp = model(op, a, b, amt, m_cnt);
            if (op == 2'd1) m_cnt = amt;
            issue(op, a, b, amt);
            check(tag_of(op, amt), out_result, exp);
            check("R1", {31'b0, out_valid}, 32'd1);
            check("R6", {27'b0, saved_cnt}, {27'b0, m_cnt});
            check("R8", {31'b0, cc}, 32'd0);
        end

        // R9 idle: valid drops and result holds
        @(negedge clk);
        check("R9", {31'b0, out_valid}, 32'd0);
        check("R9", out_result, model(2'd1, 32'hFFFF_FFFF, 32'h0, 5'd13, 5'd0));

        // R8 cc write, then shifts leave it alone
        cc_wr = 1'b1; cc_wdata = 1'b1;
        @(negedge clk);
        cc_wr = 1'b0; cc_wdata = 1'b0;
        check("R8", {31'b0, cc}, 32'd1);
        issue(2'd1, 32'h0000_0100, 32'h0, 5'd0);
        issue(2'd3, 32'h0000_0001, 32'h0, 5'd5);
        check("R8", {31'b0, cc}, 32'd1);
        // R6 SRL by 0 cleared count so funnel returns in_b (zero)
        check("R6", out_result, 32'd0);
        check("R6", {27'b0, saved_cnt}, 32'd0);

        // R6 same-edge update: SRL by 4 then funnel uses 4
        issue(2'd1, 32'h0, 32'h0, 5'd4);
        check("R6", {27'b0, saved_cnt}, 32'd4);
        issue(2'd3, 32'h0000_000F, 32'h0000_0000, 5'd0);
        check("R4", out_result, 32'hF000_0000);

        // R7 reset again clears count and cc
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R7", {27'b0, saved_cnt}, 32'd0);
        check("R7", {31'b0, cc}, 32'd0);
        check("R7", out_result, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule